// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write port of a parallel NOR-style flash controller. Every accepted write carries an address and a 16-bit word. The write strobe is synchronous and represents the moment the external write pulse is latched. The decoder interprets the low byte of each word as a command opcode, or as an operand when a sequence is open. It tracks one-cycle commands and multi-cycle sequences. It selects what a read should return: array, identifier, query or status. It also reports improper sequences through two sticky status bits.

Operations are handed to a separate operation controller as requests with a kind code, an address and a data word, using a valid/ready handshake. Suspend and resume are one-cycle pulses. Erase and program timing, the memory array and page-buffer storage all live outside this block.

The page-buffer program is passed word by word. Each loaded word becomes its own request, followed by a final commit request.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After a cycle with `rst_n` low, `read_mode` is 0 (array), `op_valid`, `susp_pulse` and `resume_pulse` are low, and both error bits are clear.
- R2: In the idle state, opcode (data bits 7:0) FFh selects read mode 0 (array), 90h selects 1 (identifier), 98h selects 2 (query) and 70h selects 3 (status).
- R3: An idle-state opcode that is not a recognised command changes neither the read mode nor the error bits, and issues nothing.
- R4: 20h followed by D0h, with both addresses in the same block (address bits ADDR_W-1:BLK_SHIFT), issues kind 1 (block erase). 30h followed by D0h at any address issues kind 2 (chip erase). The request carries the confirm cycle's address and data.
- R5: 40h or 10h, then any word, issues kind 3 (word program) with that word's address and data. C0h, then any word, issues kind 4 (one-time-area program).
- R6: 60h followed, in the same block, by 01h, D0h or 2Fh issues kind 5 (set lock), 6 (clear lock) or 7 (lock-down) respectively.
- R7: An erase, lock or page-buffer sequence that closes with a wrong confirm code or a different block sets both error bits. It issues nothing, leaves read mode 3, and returns to idle.
- R8: Idle opcode 50h clears both error bits and keeps the read mode.
- R9: E8h switches to read mode 3. A count word C of 0 to 15 follows. Then C+1 words each issue kind 8 with their own address and data. A final D0h in the block of the first loaded word issues kind 9 (commit).
- R10: A page-buffer count word above 15 sets both error bits, issues nothing, and returns to idle in read mode 3.
- R11: Every issued request leaves the read mode at 3 (status).
- R12: Idle opcode B0h gives a one-cycle `susp_pulse`, and idle opcode D0h gives a one-cycle `resume_pulse`. Both set read mode 3.
- R13: While `op_valid` is high and `op_ready` is low, kind, address and data hold steady. Writes presented while `op_valid` is high are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 16 | Write data; bits 7:0 hold the opcode |
| op_ready | input | 1 | Operation controller accepts the request |
| op_valid | output | 1 | Request pending |
| op_kind | output | 4 | Request kind code (1..9) |
| op_addr | output | ADDR_W | Request address |
| op_data | output | 16 | Request data |
| susp_pulse | output | 1 | One-cycle suspend request |
| resume_pulse | output | 1 | One-cycle resume request |
| read_mode | output | 2 | 0 array, 1 identifier, 2 query, 3 status |
| stat_erase_err | output | 1 | Sticky erase/sequence error bit |
| stat_prog_err | output | 1 | Sticky program/sequence error bit |

## Verification
Directed streams cover each command family with a correct confirm, a wrong confirm code and a foreign block. These separate a decoder that checks only the opcode from one that also checks the block. Page-buffer counts of 0, 3, 15 and 16 distinguish an off-by-one in the word counter from a wrong range check. A random stream then mixes well-formed sequences, corrupted confirms and arbitrary words. These exercise the interleavings of suspend, resume, clear and stray opcodes against a reference model. A stalled handshake shows that requests hold steady and that writes arriving during the stall are discarded.

// File: rtl/fcd_pkg.sv
// Shared types and opcode constants for the flash command sequence decoder.
package fcd_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_QUERY  = 2'd2,
        RM_STATUS = 2'd3
    } rd_mode_t;

    typedef enum logic [3:0] {
        OPK_NONE      = 4'd0,
        OPK_BLK_ERASE = 4'd1,
        OPK_CHP_ERASE = 4'd2,
        OPK_WORD_PROG = 4'd3,
        OPK_OTP_PROG  = 4'd4,
        OPK_LOCK_SET  = 4'd5,
        OPK_LOCK_CLR  = 4'd6,
        OPK_LOCK_DOWN = 4'd7,
        OPK_PB_WORD   = 4'd8,
        OPK_PB_COMMIT = 4'd9
    } op_kind_t;

    typedef enum logic [3:0] {
        CC_NONE, CC_RD_ARRAY, CC_RD_IDENT, CC_RD_QUERY, CC_RD_STATUS,
        CC_CLR_STAT, CC_SUSPEND, CC_RESUME, CC_BLK_ERASE, CC_CHP_ERASE,
        CC_PROG, CC_LOCK, CC_OTP, CC_PBUF
    } cmd_class_t;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_ERASE_CONF, SQ_CHIP_CONF, SQ_PROG_DATA, SQ_OTP_DATA,
        SQ_LOCK_CONF, SQ_PB_COUNT, SQ_PB_LOAD, SQ_PB_CONF
    } seq_state_t;

    localparam logic [7:0] OPC_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] OPC_RD_IDENT  = 8'h90;
    localparam logic [7:0] OPC_RD_QUERY  = 8'h98;
    localparam logic [7:0] OPC_RD_STATUS = 8'h70;
    localparam logic [7:0] OPC_CLR_STAT  = 8'h50;
    localparam logic [7:0] OPC_SUSPEND   = 8'hB0;
    localparam logic [7:0] OPC_CONFIRM   = 8'hD0;
    localparam logic [7:0] OPC_BLK_ERASE = 8'h20;
    localparam logic [7:0] OPC_CHP_ERASE = 8'h30;
    localparam logic [7:0] OPC_PROG_A    = 8'h40;
    localparam logic [7:0] OPC_PROG_B    = 8'h10;
    localparam logic [7:0] OPC_LOCK      = 8'h60;
    localparam logic [7:0] OPC_LOCK_SET  = 8'h01;
    localparam logic [7:0] OPC_LOCK_DOWN = 8'h2F;
    localparam logic [7:0] OPC_OTP       = 8'hC0;
    localparam logic [7:0] OPC_PBUF      = 8'hE8;

endpackage

// File: rtl/fcd_opcode_classify.sv
// Maps a first-cycle opcode byte to a command class.
// Assumes: only the low byte of the written word carries the opcode.
module fcd_opcode_classify
    import fcd_pkg::*;
(
    input  logic [7:0] opc,
    output cmd_class_t cls
);

    // Pure table lookup of the command class
    always_comb begin
        case (opc)
            OPC_RD_ARRAY:           cls = CC_RD_ARRAY;
            OPC_RD_IDENT:           cls = CC_RD_IDENT;
            OPC_RD_QUERY:           cls = CC_RD_QUERY;
            OPC_RD_STATUS:          cls = CC_RD_STATUS;
            OPC_CLR_STAT:           cls = CC_CLR_STAT;
            OPC_SUSPEND:            cls = CC_SUSPEND;
            OPC_CONFIRM:            cls = CC_RESUME;
            OPC_BLK_ERASE:          cls = CC_BLK_ERASE;
            OPC_CHP_ERASE:          cls = CC_CHP_ERASE;
            OPC_PROG_A, OPC_PROG_B: cls = CC_PROG;
            OPC_LOCK:               cls = CC_LOCK;
            OPC_OTP:                cls = CC_OTP;
            OPC_PBUF:               cls = CC_PBUF;
            default:                cls = CC_NONE;
        endcase
    end

endmodule

// File: rtl/fcd_pb_count.sv
// Down-counter of the words still to be loaded in a page-buffer sequence.
// Assumes: load and step are never asserted together.
module fcd_pb_count #(
    parameter int PB_WORDS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [$clog2(PB_WORDS)-1:0] load_val,
    input  logic                        step,
    output logic                        last
);

    localparam int CW = $clog2(PB_WORDS);

    logic [CW-1:0] cnt_q;

    // Holds the remaining word count minus one
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (step && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/fcd_sequencer.sv
// Command sequence state machine: read mode, sticky error, request issue.
// Assumes: wr_go is already gated against a pending request.
module fcd_sequencer
    import fcd_pkg::*;
#(
    parameter int BW       = 6,
    parameter int PB_WORDS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_go,
    input  logic [BW-1:0] wr_blk,
    input  logic [15:0]   wr_data,
    output logic [1:0]    mode_o,
    output logic          err_o,
    output logic          issue_o,
    output logic [3:0]    kind_o,
    output logic          susp_o,
    output logic          res_o
);

    localparam int CW = $clog2(PB_WORDS);
    localparam logic [15:0] PB_MAX = 16'(PB_WORDS - 1);

    seq_state_t    st_q, st_n;
    rd_mode_t      mode_q, mode_n;
    logic          err_q, err_n;
    logic [BW-1:0] blk_q, blk_n;
    logic          first_q, first_n;
    cmd_class_t    cls;
    logic          pb_load, pb_step, pb_last;
    op_kind_t      kind;
    logic [7:0]    opc;
    logic          same_blk;

    assign opc      = wr_data[7:0];
    assign same_blk = (wr_blk == blk_q);

    fcd_opcode_classify u_cls (
        .opc (opc),
        .cls (cls)
    );

    fcd_pb_count #(.PB_WORDS(PB_WORDS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pb_load),
        .load_val (wr_data[CW-1:0]),
        .step     (pb_step),
        .last     (pb_last)
    );

    // Next-state, mode and request decode for the accepted write
    always_comb begin
        st_n    = st_q;
        mode_n  = mode_q;
        err_n   = err_q;
        blk_n   = blk_q;
        first_n = first_q;
        issue_o = 1'b0;
        kind    = OPK_NONE;
        susp_o  = 1'b0;
        res_o   = 1'b0;
        pb_load = 1'b0;
        pb_step = 1'b0;
        if (wr_go) begin
            case (st_q)
                SQ_IDLE: begin
                    case (cls)
                        CC_RD_ARRAY:  mode_n = RM_ARRAY;
                        CC_RD_IDENT:  mode_n = RM_IDENT;
                        CC_RD_QUERY:  mode_n = RM_QUERY;
                        CC_RD_STATUS: mode_n = RM_STATUS;
                        CC_CLR_STAT:  err_n  = 1'b0;
                        CC_SUSPEND: begin
                            susp_o = 1'b1;
                            mode_n = RM_STATUS;
                        end
                        CC_RESUME: begin
                            res_o  = 1'b1;
                            mode_n = RM_STATUS;
                        end
                        CC_BLK_ERASE: begin
                            st_n  = SQ_ERASE_CONF;
                            blk_n = wr_blk;
                        end
                        CC_CHP_ERASE: st_n = SQ_CHIP_CONF;
                        CC_PROG:      st_n = SQ_PROG_DATA;
                        CC_OTP:       st_n = SQ_OTP_DATA;
                        CC_LOCK: begin
                            st_n  = SQ_LOCK_CONF;
                            blk_n = wr_blk;
                        end
                        CC_PBUF: begin
                            st_n   = SQ_PB_COUNT;
                            mode_n = RM_STATUS;
                        end
                        default: ;
                    endcase
                end
                SQ_ERASE_CONF: begin
                    st_n   = SQ_IDLE;
                    mode_n = RM_STATUS;
                    if (opc == OPC_CONFIRM && same_blk) begin
                        issue_o = 1'b1;
                        kind    = OPK_BLK_ERASE;
                    end else begin
                        err_n = 1'b1;
                    end
                end
                SQ_CHIP_CONF: begin
                    st_n   = SQ_IDLE;
                    mode_n = RM_STATUS;
                    if (opc == OPC_CONFIRM) begin
                        issue_o = 1'b1;
                        kind    = OPK_CHP_ERASE;
                    end else begin
                        err_n = 1'b1;
                    end
                end
                SQ_PROG_DATA, SQ_OTP_DATA: begin
                    st_n    = SQ_IDLE;
                    mode_n  = RM_STATUS;
                    issue_o = 1'b1;
                    kind    = (st_q == SQ_PROG_DATA) ? OPK_WORD_PROG : OPK_OTP_PROG;
                end
                SQ_LOCK_CONF: begin
                    st_n   = SQ_IDLE;
                    mode_n = RM_STATUS;
                    err_n  = 1'b1;
                    if (same_blk) begin
                        case (opc)
                            OPC_LOCK_SET:  kind = OPK_LOCK_SET;
                            OPC_CONFIRM:   kind = OPK_LOCK_CLR;
                            OPC_LOCK_DOWN: kind = OPK_LOCK_DOWN;
                            default:       kind = OPK_NONE;
                        endcase
                        if (kind != OPK_NONE) begin
                            issue_o = 1'b1;
                            err_n   = err_q;
                        end
                    end
                end
                SQ_PB_COUNT: begin
                    mode_n = RM_STATUS;
                    if (wr_data > PB_MAX) begin
                        st_n  = SQ_IDLE;
                        err_n = 1'b1;
                    end else begin
                        st_n    = SQ_PB_LOAD;
                        pb_load = 1'b1;
                        first_n = 1'b1;
                    end
                end
                SQ_PB_LOAD: begin
                    issue_o = 1'b1;
                    kind    = OPK_PB_WORD;
                    pb_step = 1'b1;
                    first_n = 1'b0;
                    if (first_q)
                        blk_n = wr_blk;
                    if (pb_last)
                        st_n = SQ_PB_CONF;
                end
                SQ_PB_CONF: begin
                    st_n   = SQ_IDLE;
                    mode_n = RM_STATUS;
                    if (opc == OPC_CONFIRM && same_blk) begin
                        issue_o = 1'b1;
                        kind    = OPK_PB_COMMIT;
                    end else begin
                        err_n = 1'b1;
                    end
                end
                default: st_n = SQ_IDLE;
            endcase
        end
    end

    // State, mode, error and block registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SQ_IDLE;
            mode_q  <= RM_ARRAY;
            err_q   <= 1'b0;
            blk_q   <= '0;
            first_q <= 1'b0;
        end else begin
            st_q    <= st_n;
            mode_q  <= mode_n;
            err_q   <= err_n;
            blk_q   <= blk_n;
            first_q <= first_n;
        end
    end

    assign mode_o = mode_q;
    assign err_o  = err_q;
    assign kind_o = kind;

endmodule

// File: rtl/fcd_req_hold.sv
// Registers requests toward the operation controller and holds them until ready.
// Assumes: issue only arrives while no request is pending.
module fcd_req_hold #(
    parameter int AW = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [3:0]    kind_in,
    input  logic [AW-1:0] addr_in,
    input  logic [15:0]   data_in,
    input  logic          susp_in,
    input  logic          res_in,
    input  logic          op_ready,
    output logic          op_valid,
    output logic [3:0]    op_kind,
    output logic [AW-1:0] op_addr,
    output logic [15:0]   op_data,
    output logic          susp_pulse,
    output logic          resume_pulse
);

    // Valid/ready holding register for one request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid <= 1'b0;
            op_kind  <= '0;
            op_addr  <= '0;
            op_data  <= '0;
        end else if (issue) begin
            op_valid <= 1'b1;
            op_kind  <= kind_in;
            op_addr  <= addr_in;
            op_data  <= data_in;
        end else if (op_valid && op_ready) begin
            op_valid <= 1'b0;
        end
    end

    // One-cycle suspend and resume pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            susp_pulse   <= 1'b0;
            resume_pulse <= 1'b0;
        end else begin
            susp_pulse   <= susp_in;
            resume_pulse <= res_in;
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
// Top: decodes bus writes into flash operation requests and a read mode.
// Assumes: one write per wr_en cycle; writes during a pending request are dropped.
module flash_cmd_decoder #(
    parameter int ADDR_W    = 21,
    parameter int BLK_SHIFT = 15,
    parameter int PB_WORDS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              op_ready,
    output logic              op_valid,
    output logic [3:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [15:0]       op_data,
    output logic              susp_pulse,
    output logic              resume_pulse,
    output logic [1:0]        read_mode,
    output logic              stat_erase_err,
    output logic              stat_prog_err
);

    localparam int BLK_W = ADDR_W - BLK_SHIFT;

    logic             wr_go;
    logic [BLK_W-1:0] wr_blk;
    logic             issue, susp_now, res_now, seq_err;
    logic [3:0]       kind;

    assign wr_go  = wr_en && !op_valid;
    assign wr_blk = wr_addr[ADDR_W-1:BLK_SHIFT];

    fcd_sequencer #(.BW(BLK_W), .PB_WORDS(PB_WORDS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (wr_go),
        .wr_blk  (wr_blk),
        .wr_data (wr_data),
        .mode_o  (read_mode),
        .err_o   (seq_err),
        .issue_o (issue),
        .kind_o  (kind),
        .susp_o  (susp_now),
        .res_o   (res_now)
    );

    fcd_req_hold #(.AW(ADDR_W)) u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue        (issue),
        .kind_in      (kind),
        .addr_in      (wr_addr),
        .data_in      (wr_data),
        .susp_in      (susp_now),
        .res_in       (res_now),
        .op_ready     (op_ready),
        .op_valid     (op_valid),
        .op_kind      (op_kind),
        .op_addr      (op_addr),
        .op_data      (op_data),
        .susp_pulse   (susp_pulse),
        .resume_pulse (resume_pulse)
    );

    assign stat_erase_err = seq_err;
    assign stat_prog_err  = seq_err;

endmodule

// File: rtl/fcd_checker.sv
// Temporal properties of the decoder's ports, attached by bind.
module fcd_checker #(
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              op_ready,
    input logic              op_valid,
    input logic [3:0]        op_kind,
    input logic [ADDR_W-1:0] op_addr,
    input logic [15:0]       op_data,
    input logic              susp_pulse,
    input logic              resume_pulse,
    input logic [1:0]        read_mode,
    input logic              stat_erase_err,
    input logic              stat_prog_err
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (read_mode == 2'd0 && !op_valid && !stat_erase_err && !stat_prog_err));

    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_ready) |=> (op_valid && $stable(op_kind) && $stable(op_addr) && $stable(op_data)));

    // R13
    drop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op_valid) |=> $stable(read_mode));

    // R11
    req_status_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> read_mode == 2'd3);

    // R12
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_pulse || resume_pulse) |=> !(susp_pulse || resume_pulse));

    // R7
    err_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_erase_err) |-> (!op_valid && $rose(stat_prog_err)));

endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W)) u_fcd_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .op_ready       (op_ready),
    .op_valid       (op_valid),
    .op_kind        (op_kind),
    .op_addr        (op_addr),
    .op_data        (op_data),
    .susp_pulse     (susp_pulse),
    .resume_pulse   (resume_pulse),
    .read_mode      (read_mode),
    .stat_erase_err (stat_erase_err),
    .stat_prog_err  (stat_prog_err)
);

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

    localparam int AW = 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic          op_ready = 1'b1;
    logic          op_valid, susp_pulse, resume_pulse, err_e, err_p;
    logic [3:0]    op_kind;
    logic [AW-1:0] op_addr;
    logic [15:0]   op_data;
    logic [1:0]    read_mode;

    int  nchk = 0, nfail = 0;
    bit  done = 1'b0;

    // model state
    int       m_st = 0, m_left = 0;
    logic [1:0] m_mode = 2'd0;
    bit       m_err = 1'b0, m_first = 1'b0;
    logic [5:0] m_blk = '0;
    bit       e_op, e_susp, e_res;
    int       e_kind;
    string    m_tag;

    always #4 clk = ~clk;

    flash_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .op_ready(op_ready), .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr),
        .op_data(op_data), .susp_pulse(susp_pulse), .resume_pulse(resume_pulse),
        .read_mode(read_mode), .stat_erase_err(err_e), .stat_prog_err(err_p)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mkaddr(input int blk);
        return {blk[5:0], 15'($urandom)};
    endfunction

    // Reference model of the requirements for one accepted write
    task automatic model(input logic [AW-1:0] a, input logic [15:0] d);
        logic [5:0] b = a[AW-1:15];
        logic [7:0] o = d[7:0];
        e_op = 0; e_kind = 0; e_susp = 0; e_res = 0; m_tag = "R3";
        case (m_st)
            0: case (o)
                8'hFF: begin m_mode = 0; m_tag = "R2"; end
                8'h90: begin m_mode = 1; m_tag = "R2"; end
                8'h98: begin m_mode = 2; m_tag = "R2"; end
                8'h70: begin m_mode = 3; m_tag = "R2"; end
                8'h50: begin m_err = 0; m_tag = "R8"; end
                8'hB0: begin e_susp = 1; m_mode = 3; m_tag = "R12"; end
                8'hD0: begin e_res = 1; m_mode = 3; m_tag = "R12"; end
                8'h20: begin m_st = 1; m_blk = b; m_tag = "R4"; end
                8'h30: begin m_st = 2; m_tag = "R4"; end
                8'h40, 8'h10: begin m_st = 3; m_tag = "R5"; end
                8'hC0: begin m_st = 4; m_tag = "R5"; end
                8'h60: begin m_st = 5; m_blk = b; m_tag = "R6"; end
                8'hE8: begin m_st = 6; m_mode = 3; m_tag = "R9"; end
                default: m_tag = "R3";
            endcase
            1, 2: begin
                m_mode = 3;
                if (o == 8'hD0 && (m_st == 2 || b == m_blk)) begin
                    e_op = 1; e_kind = m_st; m_tag = "R4 R11";
                end else begin
                    m_err = 1; m_tag = "R7";
                end
                m_st = 0;
            end
            3, 4: begin
                m_mode = 3; e_op = 1; e_kind = m_st; m_st = 0; m_tag = "R5 R11";
            end
            5: begin
                m_mode = 3; m_st = 0;
                if (b == m_blk && (o == 8'h01 || o == 8'hD0 || o == 8'h2F)) begin
                    e_op = 1; m_tag = "R6 R11";
                    e_kind = (o == 8'h01) ? 5 : (o == 8'hD0) ? 6 : 7;
                end else begin
                    m_err = 1; m_tag = "R7";
                end
            end
            6: begin
                if (d > 16'd15) begin
                    m_err = 1; m_st = 0; m_tag = "R10";
                end else begin
                    m_left = int'(d) + 1; m_st = 7; m_first = 1; m_tag = "R9";
                end
            end
            7: begin
                e_op = 1; e_kind = 8; m_tag = "R9 R11";
                if (m_first) m_blk = b;
                m_first = 0;
                m_left--;
                if (m_left == 0) m_st = 8;
            end
            default: begin
                m_mode = 3; m_st = 0;
                if (o == 8'hD0 && b == m_blk) begin
                    e_op = 1; e_kind = 9; m_tag = "R9 R11";
                end else begin
                    m_err = 1; m_tag = "R7";
                end
            end
        endcase
    endtask

    task automatic check_now(input logic [AW-1:0] a, input logic [15:0] d);
        chk({m_tag, " mode"}, 32'(read_mode), 32'(m_mode));
        chk({m_tag, " err"}, {30'd0, err_e, err_p}, {30'd0, m_err, m_err});
        chk({m_tag, " valid"}, 32'(op_valid), 32'(e_op));
        if (e_op) begin
            chk({m_tag, " kind"}, 32'(op_kind), 32'(e_kind));
            chk({m_tag, " addr"}, 32'(op_addr), 32'(a));
            chk({m_tag, " data"}, 32'(op_data), 32'(d));
        end
        chk({m_tag, " pulses"}, {30'd0, susp_pulse, resume_pulse}, {30'd0, e_susp, e_res});
    endtask

    // One bus write, checked one cycle later, with the request drained
    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        model(a, d);
        @(negedge clk);
        wr_en = 0;
        check_now(a, d);
        @(negedge clk);
        if (e_susp || e_res)
            chk("R12 pulse width", {30'd0, susp_pulse, resume_pulse}, 32'd0);
    endtask

    task automatic pbuf(input int blk, input int cnt, input bit good);
        wr(mkaddr(blk), 16'h00E8);
        wr(mkaddr(blk), 16'(cnt));
        if (cnt <= 15) begin
            for (int i = 0; i <= cnt; i++) wr(mkaddr(blk), 16'($urandom));
            wr(mkaddr(good ? blk : blk + 1), 16'h00D0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 mode", 32'(read_mode), 32'd0);
        chk("R1 valid", 32'(op_valid), 32'd0);
        chk("R1 err", {30'd0, err_e, err_p}, 32'd0);
        chk("R1 pulses", {30'd0, susp_pulse, resume_pulse}, 32'd0);
        rst_n = 1;
        // R2 and R3 read modes and stray opcode
        wr(21'h0, 16'h0090); wr(21'h0, 16'h0012); wr(21'h0, 16'h0098);
        wr(21'h0, 16'h0070); wr(21'h0, 16'h00FF); wr(21'h0, 16'h00A5);
        // R4 erase families
        wr(mkaddr(3), 16'h0020); wr(mkaddr(3), 16'h00D0);
        wr(mkaddr(1), 16'h0030); wr(mkaddr(5), 16'h00D0);
        // R5 program and one-time area program
        wr(mkaddr(2), 16'h0040); wr(mkaddr(2), 16'h1234);
        wr(mkaddr(2), 16'h0010); wr(mkaddr(4), 16'hBEEF);
        wr(mkaddr(0), 16'h00C0); wr(21'h000082, 16'h5A5A);
        // R6 lock commands
        wr(mkaddr(7), 16'h0060); wr(mkaddr(7), 16'h0001);
        wr(mkaddr(7), 16'h0060); wr(mkaddr(7), 16'h00D0);
        wr(mkaddr(7), 16'h0060); wr(mkaddr(7), 16'h002F);
        // R7 improper sequences, R8 clear
        wr(mkaddr(1), 16'h0020); wr(mkaddr(1), 16'h00FF);
        wr(21'h0, 16'h0090); wr(21'h0, 16'h0050);
        wr(mkaddr(1), 16'h0060); wr(mkaddr(2), 16'h0001);
        wr(21'h0, 16'h0050);
        wr(mkaddr(1), 16'h0030); wr(mkaddr(1), 16'h0020);
        wr(21'h0, 16'h0050);
        // R9 page buffer, R10 overflow count
        pbuf(6, 3, 1); pbuf(6, 0, 1); pbuf(2, 15, 1); pbuf(2, 2, 0);
        wr(21'h0, 16'h0050);
        pbuf(4, 16, 1);
        wr(21'h0, 16'h0050);
        // R12 suspend and resume
        wr(21'h0, 16'h00FF); wr(21'h0, 16'h00B0); wr(21'h0, 16'h00FF); wr(21'h0, 16'h00D0);
        // R13 stalled handshake and dropped write
        op_ready = 0;
        wr(mkaddr(3), 16'h0040);
        @(negedge clk); wr_en = 1; wr_addr = 21'h01ABCD; wr_data = 16'hC0DE;
        model(21'h01ABCD, 16'hC0DE);
        @(negedge clk); wr_en = 1; wr_addr = 21'h0; wr_data = 16'h00FF;
        @(negedge clk); wr_en = 0;
        check_now(21'h01ABCD, 16'hC0DE);
        @(negedge clk);
        chk("R13 held valid", 32'(op_valid), 32'd1);
        chk("R13 held addr", 32'(op_addr), 32'h01ABCD);
        chk("R13 dropped write", 32'(read_mode), 32'd3);
        op_ready = 1;
        @(negedge clk);
        chk("R13 released", 32'(op_valid), 32'd0);
        wr(21'h0, 16'h0090);
        // constrained random mix
        for (int n = 0; n < 300; n++) begin
            int blk = $urandom_range(0, 3);
            bit good = ($urandom_range(0, 9) < 8);
            case ($urandom_range(0, 7))
                0: wr(mkaddr(blk), 16'($urandom_range(0, 255)));
                1: begin wr(mkaddr(blk), 16'h0020);
                         wr(mkaddr(good ? blk : blk + 1), good ? 16'h00D0 : 16'h0001); end
                2: begin wr(mkaddr(blk), 16'h0030); wr(mkaddr(blk), good ? 16'h00D0 : 16'h0070); end
                3: begin wr(mkaddr(blk), ($urandom_range(0, 1) != 0) ? 16'h0040 : 16'h0010);
                         wr(mkaddr(blk), 16'($urandom)); end
                4: begin wr(mkaddr(blk), 16'h0060);
                         wr(mkaddr(good ? blk : blk + 2),
                            16'($urandom_range(0, 2) == 0 ? 8'h01 : $urandom_range(0, 1) != 0 ? 8'hD0 : 8'h2F)); end
                5: pbuf(blk, $urandom_range(0, 17), good);
                6: wr(mkaddr(blk), ($urandom_range(0, 1) != 0) ? 16'h00B0 : 16'h0050);
                default: wr(mkaddr(blk), 16'($urandom));
            endcase
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule